// File: doc/BRIEF.md
# Three-Slot Micro-Op Decode Allocator

This block sits between instruction fetch and register rename. Each cycle it sees up to three macro-instructions in program order. Each one carries the number of micro-ops it expands to and an opaque payload. The block decides in the same cycle which of them can be decoded. It expands the accepted ones into micro-op entries and appends those entries to a six-entry micro-op queue. The rename stage takes up to three entries per cycle from the head of that queue.

The decode slots are asymmetric. Slot 0 may produce up to four micro-ops, and slots 1 and 2 may produce only one each, so one cycle never produces more than six. Acceptance stops at the first slot that cannot be taken. A slot cannot be taken when it is empty, when it asks for more micro-ops than its slot allows, or when its micro-ops do not fit in the queue. Fetch is expected to shift the rejected instructions down, so a long instruction rejected in slot 1 or 2 is accepted later from slot 0. A flush input cancels the cycle and empties the queue.

Top module: `decode_alloc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `q_count` is 0 and every queue entry reads as 0.
- R2: Slot 0 is accepted only with a micro-op count from 1 to 4. Slots 1 and 2 are accepted only with a count of exactly 1. A valid slot whose count is 0 or above its limit is rejected, and so is every later slot.
- R3: Acceptance is strictly in order: slot i is accepted only if every lower slot is valid and accepted in the same cycle.
- R4: A slot is accepted only if its micro-ops, added to those of the lower accepted slots, fit in the free space. Free space is 6 minus `q_count` plus `drain_cnt` of the same cycle.
- R5: `drain_cnt` equals the smaller of `drain_req` and `q_count`, or 0 during flush. That many entries leave the head (entry 0) at the clock edge, and the remaining entries move toward the head.
- R6: After each edge without flush, the new entries follow the remaining ones in slot order, and the micro-ops of one instruction stay in sequence. The new `q_count` is the old count minus `drain_cnt` plus the accepted micro-ops.
- R7: While `flush` is high, no slot is accepted, `drain_cnt` is 0 and `stall` is low. After the next edge the queue is empty.
- R8: `stall` is high exactly when `flush` is low and some valid slot is not accepted.
- R9: Each queue entry holds the micro-op index within its instruction in bits [1:0] (0 for the first) and the instruction payload in bits [9:2]. Entry j sits in `q_entries[10*j +: 10]`, and every entry at or above `q_count` reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Cancel this cycle's decode and empty the queue |
| in_valid | input | 3 | Per-slot instruction present, bit i for slot i |
| in_nuops | input | 9 | Per-slot micro-op count, 3 bits per slot, slot i at [3i+2:3i] |
| in_payload | input | 24 | Per-slot opaque payload, 8 bits per slot, slot i at [8i+7:8i] |
| drain_req | input | 2 | Number of micro-ops rename wants to take this cycle |
| in_accept | output | 3 | Per-slot accept, bit i for slot i |
| stall | output | 1 | Some presented instruction was not accepted |
| drain_cnt | output | 2 | Number of micro-ops leaving the head at the coming edge |
| q_count | output | 3 | Number of valid queue entries |
| q_entries | output | 60 | Queue contents, head at entry 0, 10 bits per entry |

## Verification
The assertions assume that the producer shifts unaccepted instructions down by itself. They also assume that every input is held stable between edges, because acceptance and drain are computed combinationally from the inputs and the queue state. The checker does not check what the payload contains. It checks only the slot limits, the ordering, the space rule and how the count changes over time. The stimulus therefore sweeps every combination of valid mask and per-slot count from 0 to 7, including counts that are illegal for a slot, while the drain request varies and a flush occurs now and then. It drives all inputs at the falling edge. A directed sequence then shows a four-micro-op instruction rejected in slot 1 and accepted once it is in slot 0.

// File: rtl/dal_pkg.sv
package dal_pkg;
   // Micro-op capacity of a decode slot: the first slot is the wide one.
   function automatic int slot_cap(input int idx, input int wide, input int narrow);
      return (idx == 0) ? wide : narrow;
   endfunction

   // Bits needed to number the micro-ops of one instruction (at least one).
   function automatic int idx_bits(input int wide);
      return (wide > 1) ? $clog2(wide) : 1;
   endfunction
endpackage

// File: rtl/dal_slot_gate.sv
module dal_slot_gate #(
   parameter int NUM_SLOTS  = 3,
   parameter int WIDE_MAX   = 4,
   parameter int NARROW_MAX = 1,
   parameter int NUOP_W     = 3,
   parameter int SUM_W      = 4
) (
   input  logic                          flush,
   input  logic [NUM_SLOTS-1:0]          in_valid,
   input  logic [NUM_SLOTS*NUOP_W-1:0]   in_nuops,
   input  logic [SUM_W-1:0]              free_space,
   output logic [NUM_SLOTS-1:0]          accept,
   output logic [SUM_W-1:0]              added
);
   logic [NUM_SLOTS-1:0] cap_ok;

   genvar gs;
   generate
      for (gs = 0; gs < NUM_SLOTS; gs++) begin : g_cap
         localparam int CAP = dal_pkg::slot_cap(gs, WIDE_MAX, NARROW_MAX);
         logic [NUOP_W-1:0] n;
         assign n = in_nuops[gs*NUOP_W +: NUOP_W];
         assign cap_ok[gs] = (n != '0) && (n <= NUOP_W'(CAP));
      end
   endgenerate

   always_comb begin
      logic [SUM_W-1:0] run;
      logic [SUM_W-1:0] need;
      logic             go;
      run = '0;
      go  = !flush;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         need = SUM_W'(in_nuops[s*NUOP_W +: NUOP_W]);
         go   = go && in_valid[s] && cap_ok[s] && ((run + need) <= free_space);
         accept[s] = go;
         if (go) run = run + need;
      end
      added = run;
   end
endmodule

// File: rtl/dal_uop_expand.sv
module dal_uop_expand #(
   parameter int NUM_SLOTS = 3,
   parameter int NUOP_W    = 3,
   parameter int PAYLOAD_W = 8,
   parameter int IDX_W     = 2,
   parameter int EXP_MAX   = 6,
   parameter int ENTRY_W   = PAYLOAD_W + IDX_W
) (
   input  logic [NUM_SLOTS-1:0]           accept,
   input  logic [NUM_SLOTS*NUOP_W-1:0]    in_nuops,
   input  logic [NUM_SLOTS*PAYLOAD_W-1:0] in_payload,
   output logic [EXP_MAX*ENTRY_W-1:0]     uop_list
);
   always_comb begin
      int start;
      int n;
      uop_list = '0;
      start = 0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         n = accept[s] ? int'(in_nuops[s*NUOP_W +: NUOP_W]) : 0;
         for (int p = 0; p < EXP_MAX; p++) begin
            if (p >= start && p < start + n)
               uop_list[p*ENTRY_W +: ENTRY_W] =
                  {in_payload[s*PAYLOAD_W +: PAYLOAD_W], IDX_W'(p - start)};
         end
         start = start + n;
      end
   end
endmodule

// File: rtl/dal_uop_queue.sv
module dal_uop_queue #(
   parameter int DEPTH     = 6,
   parameter int ENTRY_W   = 10,
   parameter int EXP_MAX   = 6,
   parameter int DRAIN_MAX = 3,
   parameter int CNT_W     = 3,
   parameter int DRAIN_W   = 2,
   parameter int SUM_W     = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic [DRAIN_W-1:0]         drain_req,
   input  logic [EXP_MAX*ENTRY_W-1:0] uop_list,
   input  logic [SUM_W-1:0]           added,
   output logic [DEPTH*ENTRY_W-1:0]   entries,
   output logic [CNT_W-1:0]           count,
   output logic [DRAIN_W-1:0]         drain_cnt,
   output logic [SUM_W-1:0]           free_space
);
   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [ENTRY_W-1:0] nxt [DEPTH];
   logic [SUM_W-1:0]   cnt_s, req_s, dc_s;

   always_comb begin
      cnt_s = SUM_W'(count);
      req_s = SUM_W'(drain_req);
      if (req_s > SUM_W'(DRAIN_MAX)) req_s = SUM_W'(DRAIN_MAX);
      if (flush)              dc_s = '0;
      else if (req_s < cnt_s) dc_s = req_s;
      else                    dc_s = cnt_s;
   end

   assign drain_cnt  = DRAIN_W'(dc_s);
   assign free_space = SUM_W'(DEPTH) - cnt_s + dc_s;

   always_comb begin
      int keep, src, li;
      keep = int'(cnt_s) - int'(dc_s);
      for (int j = 0; j < DEPTH; j++) begin
         nxt[j] = '0;
         src = j + int'(dc_s);
         li  = j - keep;
         if (j < keep) begin
            if (src < DEPTH) nxt[j] = mem[src];
         end else if (li < int'(added) && li < EXP_MAX) begin
            nxt[j] = uop_list[li*ENTRY_W +: ENTRY_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         count <= '0;
         for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
      end else begin
         count <= CNT_W'(cnt_s - dc_s + added);
         for (int j = 0; j < DEPTH; j++) mem[j] <= nxt[j];
      end
   end

   genvar ge;
   generate
      for (ge = 0; ge < DEPTH; ge++) begin : g_out
         assign entries[ge*ENTRY_W +: ENTRY_W] = mem[ge];
      end
   endgenerate
endmodule

// File: rtl/decode_alloc.sv
module decode_alloc #(
   parameter int NUM_SLOTS   = 3,
   parameter int WIDE_MAX    = 4,
   parameter int NARROW_MAX  = 1,
   parameter int NUOP_W      = 3,
   parameter int PAYLOAD_W   = 8,
   parameter int QUEUE_DEPTH = 6,
   parameter int DRAIN_MAX   = 3,
   localparam int IDX_W      = dal_pkg::idx_bits(WIDE_MAX),
   localparam int ENTRY_W    = PAYLOAD_W + IDX_W,
   localparam int EXP_MAX    = WIDE_MAX + (NUM_SLOTS - 1) * NARROW_MAX,
   localparam int CNT_W      = $clog2(QUEUE_DEPTH + 1),
   localparam int DRAIN_W    = $clog2(DRAIN_MAX + 1)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             flush,
   input  logic [NUM_SLOTS-1:0]             in_valid,
   input  logic [NUM_SLOTS*NUOP_W-1:0]      in_nuops,
   input  logic [NUM_SLOTS*PAYLOAD_W-1:0]   in_payload,
   input  logic [DRAIN_W-1:0]               drain_req,
   output logic [NUM_SLOTS-1:0]             in_accept,
   output logic                             stall,
   output logic [DRAIN_W-1:0]               drain_cnt,
   output logic [CNT_W-1:0]                 q_count,
   output logic [QUEUE_DEPTH*ENTRY_W-1:0]   q_entries
);
   localparam int SUM_W = $clog2(QUEUE_DEPTH + DRAIN_MAX + EXP_MAX + 1);

   generate
      if (NUM_SLOTS < 1)                 begin : g_bad_slots  $error("need at least one slot"); end
      if (WIDE_MAX >= (1 << NUOP_W))     begin : g_bad_nuop   $error("count field too narrow"); end
      if (NARROW_MAX > WIDE_MAX)         begin : g_bad_narrow $error("narrow slot exceeds wide slot"); end
      if (WIDE_MAX > QUEUE_DEPTH)        begin : g_bad_depth  $error("wide instruction cannot fit queue"); end
      if (DRAIN_MAX < 1)                 begin : g_bad_drain  $error("drain width must be positive"); end
   endgenerate

   logic [SUM_W-1:0]           free_space;
   logic [SUM_W-1:0]           added;
   logic [EXP_MAX*ENTRY_W-1:0] uop_list;

   dal_slot_gate #(
      .NUM_SLOTS(NUM_SLOTS), .WIDE_MAX(WIDE_MAX), .NARROW_MAX(NARROW_MAX),
      .NUOP_W(NUOP_W), .SUM_W(SUM_W)
   ) u_gate (
      .flush(flush), .in_valid(in_valid), .in_nuops(in_nuops),
      .free_space(free_space), .accept(in_accept), .added(added)
   );

   dal_uop_expand #(
      .NUM_SLOTS(NUM_SLOTS), .NUOP_W(NUOP_W), .PAYLOAD_W(PAYLOAD_W),
      .IDX_W(IDX_W), .EXP_MAX(EXP_MAX), .ENTRY_W(ENTRY_W)
   ) u_expand (
      .accept(in_accept), .in_nuops(in_nuops), .in_payload(in_payload),
      .uop_list(uop_list)
   );

   dal_uop_queue #(
      .DEPTH(QUEUE_DEPTH), .ENTRY_W(ENTRY_W), .EXP_MAX(EXP_MAX),
      .DRAIN_MAX(DRAIN_MAX), .CNT_W(CNT_W), .DRAIN_W(DRAIN_W), .SUM_W(SUM_W)
   ) u_queue (
      .clk(clk), .rst_n(rst_n), .flush(flush), .drain_req(drain_req),
      .uop_list(uop_list), .added(added), .entries(q_entries),
      .count(q_count), .drain_cnt(drain_cnt), .free_space(free_space)
   );

   assign stall = !flush && |(in_valid & ~in_accept);
endmodule

// File: rtl/decode_alloc_chk.sv
module decode_alloc_chk #(
   parameter int NUM_SLOTS   = 3,
   parameter int WIDE_MAX    = 4,
   parameter int NARROW_MAX  = 1,
   parameter int NUOP_W      = 3,
   parameter int QUEUE_DEPTH = 6,
   parameter int DRAIN_MAX   = 3,
   parameter int CNT_W       = 3,
   parameter int DRAIN_W     = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        flush,
   input logic [NUM_SLOTS-1:0]        in_valid,
   input logic [NUM_SLOTS*NUOP_W-1:0] in_nuops,
   input logic [NUM_SLOTS-1:0]        in_accept,
   input logic                        stall,
   input logic [DRAIN_W-1:0]          drain_cnt,
   input logic [CNT_W-1:0]            q_count
);
   int add_sum;
   always_comb begin
      add_sum = 0;
      for (int s = 0; s < NUM_SLOTS; s++)
         if (in_accept[s]) add_sum = add_sum + int'(in_nuops[s*NUOP_W +: NUOP_W]);
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(q_count) <= QUEUE_DEPTH); // R6
   AST_DRAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (drain_cnt <= DRAIN_W'(DRAIN_MAX)) && (int'(drain_cnt) <= int'(q_count))); // R5
   AST_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(q_count) - int'(drain_cnt) + add_sum <= QUEUE_DEPTH); // R4
   AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (in_accept == '0) && (drain_cnt == '0) && !stall); // R7
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (q_count == '0)); // R7
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(flush)) |->
      int'(q_count) == int'($past(q_count)) - int'($past(drain_cnt)) + $past(add_sum)); // R6
   AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (in_valid != in_accept)); // R8

   genvar gs;
   generate
      for (gs = 0; gs < NUM_SLOTS; gs++) begin : g_slot
         localparam int CAP = (gs == 0) ? WIDE_MAX : NARROW_MAX;
         AST_SLOT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
            in_accept[gs] |-> in_valid[gs]
               && (int'(in_nuops[gs*NUOP_W +: NUOP_W]) >= 1)
               && (int'(in_nuops[gs*NUOP_W +: NUOP_W]) <= CAP)); // R2
         if (gs > 0) begin : g_ord
            AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
               in_accept[gs] |-> in_accept[gs-1]); // R3
         end
      end
   endgenerate
endmodule

bind decode_alloc decode_alloc_chk #(
   .NUM_SLOTS(NUM_SLOTS), .WIDE_MAX(WIDE_MAX), .NARROW_MAX(NARROW_MAX),
   .NUOP_W(NUOP_W), .QUEUE_DEPTH(QUEUE_DEPTH), .DRAIN_MAX(DRAIN_MAX),
   .CNT_W(CNT_W), .DRAIN_W(DRAIN_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
   .in_nuops(in_nuops), .in_accept(in_accept), .stall(stall),
   .drain_cnt(drain_cnt), .q_count(q_count)
);

// File: tb/decode_alloc_test.sv
`timescale 1ns/1ps
module decode_alloc_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [2:0]  in_valid = '0;
   logic [8:0]  in_nuops = '0;
   logic [23:0] in_payload = '0;
   logic [1:0]  drain_req = '0;
   logic [2:0]  in_accept;
   logic        stall;
   logic [1:0]  drain_cnt;
   logic [2:0]  q_count;
   logic [59:0] q_entries;

   int nchk = 0;
   int nerr = 0;
   int mq[6];
   int mcnt = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   decode_alloc uut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
      .in_nuops(in_nuops), .in_payload(in_payload), .drain_req(drain_req),
      .in_accept(in_accept), .stall(stall), .drain_cnt(drain_cnt),
      .q_count(q_count), .q_entries(q_entries)
   );

   task automatic check(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_queue(input string tag);
      check({tag, " R6 count"}, int'(q_count), mcnt);
      for (int j = 0; j < 6; j++)
         check((j < mcnt) ? {tag, " R6 R9 entry"} : {tag, " R9 empty entry"},
               int'(q_entries[j*10 +: 10]), (j < mcnt) ? mq[j] : 0);
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic step(input bit fl, input bit [2:0] v, input int n0, input int n1,
                       input int n2, input int dr, input int pbase);
      int n[3];
      int pay[3];
      int lst[6];
      int dc, fr, run, cap, ds;
      bit go, exp_stall;
      bit [2:0] acc;
      n[0] = n0; n[1] = n1; n[2] = n2;
      for (int s = 0; s < 3; s++) pay[s] = (pbase + s * 37) & 255;
      flush      = fl;
      in_valid   = v;
      in_nuops   = {3'(n2), 3'(n1), 3'(n0)};
      in_payload = {8'(pay[2]), 8'(pay[1]), 8'(pay[0])};
      drain_req  = 2'(dr);
      #1;
      ds  = (dr > 3) ? 3 : dr;
      dc  = fl ? 0 : ((ds < mcnt) ? ds : mcnt);
      fr  = 6 - mcnt + dc;
      run = 0;
      go  = !fl;
      acc = '0;
      for (int s = 0; s < 3; s++) begin
         cap = (s == 0) ? 4 : 1;
         go  = go && v[s] && n[s] >= 1 && n[s] <= cap && (run + n[s] <= fr);
         acc[s] = go;
         if (go) begin
            for (int k = 0; k < n[s]; k++) lst[run + k] = pay[s] * 4 + k;
            run = run + n[s];
         end
      end
      exp_stall = !fl && |(v & ~acc);
      check(fl ? "R7 accept" : "R2 R3 R4 accept", int'(in_accept), int'(acc));
      check(fl ? "R7 drain" : "R5 drain", int'(drain_cnt), dc);
      check(fl ? "R7 stall" : "R8 stall", int'(stall), int'(exp_stall));
      @(posedge clk);
      if (fl) mcnt = 0;
      else begin
         for (int j = 0; j < mcnt - dc; j++) mq[j] = mq[j + dc];
         mcnt = mcnt - dc;
         for (int k = 0; k < run; k++) mq[mcnt + k] = lst[k];
         mcnt = mcnt + run;
      end
      @(negedge clk);
      check_queue(fl ? "R7" : "R5");
   endtask

   initial begin
      #1000000;
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 count in reset", int'(q_count), 0);
      check("R1 entries in reset", int'(q_entries != '0), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 count after reset", int'(q_count), 0);
      check("R1 entries after reset", int'(q_entries != '0), 0);

      // Sweep: every valid mask and every per-slot count 0..7.
      for (int i = 0; i < 4096; i++) begin
         step((i % 211) == 100, 3'(i >> 9), i & 7, (i >> 3) & 7, (i >> 6) & 7,
              (i ^ (i >> 2)) & 3, i);
      end

      // Directed R2: a four-micro-op instruction stuck in slot 1 moves to slot 0.
      step(1'b1, 3'b000, 0, 0, 0, 0, 0);
      step(1'b0, 3'b111, 1, 4, 1, 0, 11);
      check("R2 wide in slot 1 rejected", int'(in_accept), 3'b001);
      step(1'b0, 3'b011, 4, 1, 0, 3, 12);
      // Queue holds 5: nothing fits until drained.
      step(1'b0, 3'b001, 2, 0, 0, 0, 13);
      step(1'b0, 3'b001, 2, 0, 0, 1, 14);
      step(1'b0, 3'b111, 1, 1, 1, 3, 15);
      step(1'b1, 3'b111, 1, 1, 1, 3, 16);
      step(1'b0, 3'b111, 4, 1, 1, 0, 17);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule